// File: doc/BRIEF.md
# Floating-Point Immediate Constructor

This block builds 64-bit double-precision register values from 16-bit immediates. It has two operations. The load-high operation places a 16-bit immediate in the upper half of a single-precision word, zeroes the lower half, and widens the word to double format. That is the same as widening a bfloat16 value. The set-low operation is a read-modify-write. It narrows the register's current double value to single precision, replaces the lower 16 bits of that single word with a new immediate, and widens the result again.

A load-high followed by a set-low on the same register rebuilds any 32-bit single-precision constant exactly. The set-low operation looks only at the single-precision view of the old value and drops the remaining bits. Neither operation produces floating-point status or exception flags. The result is registered and appears one clock after the request.

A two-state output machine drives the output strobe. The states are:
- `ST_IDLE`: no result this cycle.
- `ST_EMIT`: a fresh result is on `out_data`.

Any state moves to `ST_EMIT` when `in_vld` is high and to `ST_IDLE` when it is low. Reset forces `ST_IDLE`.

Top module: `fpimm_build`

## Requirements
- R1: `rst` is synchronous and active high. After any clock edge at which `rst` is high, `out_vld` is 0.
- R2: `out_vld` is 1 exactly in the cycle that follows a clock edge at which `in_vld` was 1. In that cycle `out_data` holds the result for the inputs sampled at that edge.
- R3: With `in_op` = 0 (load-high), the single-precision word is {`in_imm`, 16 zero bits}, and the result is that word widened to double. `in_old` has no effect, and result bits 28..0 are zero.
- R4: With `in_op` = 1 (set-low), the result is built in three steps. First `in_old` is narrowed to single precision. Then the upper 16 bits of that word are kept and the lower 16 bits are replaced by `in_imm`. Finally the word is widened to double.
- R5: Widening a normal single value keeps the sign, adds 896 to the 8-bit exponent to form the 11-bit exponent, and appends 29 zero bits below the 23-bit mantissa.
- R6: A single-precision zero widens to a double zero of the same sign. A single value with an all-ones exponent widens to exponent 0x7FF, keeping its sign and its mantissa padded with 29 zeros.
- R7: A single-precision denormal whose highest set mantissa bit is bit p widens to a normal double. Its exponent is p+874, and the mantissa bits below bit p are left-aligned in the 52-bit double mantissa.
- R8: Narrowing keeps the sign and truncates without rounding. Mantissa bits 28..0 of `in_old` are ignored except for the NaN case below. The double exponent E maps as follows:
  - E = 0x7FF gives exponent 0xFF with mantissa bits 51..29. If those bits are zero but lower bits are set, mantissa bit 22 is set instead.
  - E > 1150 gives a signed infinity.
  - E from 897 to 1150 gives exponent E−896.
  - E from 874 to 896 gives a denormal with mantissa ({1, bits 51..29} >> (897−E)).
  - E below 874 gives a signed zero.
- R9: Take any 32-bit constant c. A load-high with c[31:16], followed by a set-low with c[15:0] and the load-high result as `in_old`, yields c widened to double exactly.
- R10: After a clock edge at which `in_vld` is 0, `out_data` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Request strobe |
| in_op | input | 1 | 0 = load-high, 1 = set-low |
| in_imm | input | 16 | Immediate half-word |
| in_old | input | 64 | Current double-format register value (set-low only) |
| out_vld | output | 1 | Result strobe |
| out_data | output | 64 | New double-format register value |

## Verification
Every result is due in the cycle after the edge that samples its request. The bench therefore drives inputs on the falling edge and checks each expectation at the next falling edge, after exactly one rising edge has passed. Its reference model is written behaviourally and computes, for every drive, both the expected strobe and either the expected data or, for idle cycles, the held data. For the chained cases, the bench feeds the set-low request with the `out_data` it has just checked, so the comparison covers the real two-step round trip.

// File: rtl/fpimm_pkg.sv
package fpimm_pkg;
    localparam int IMM_W     = 16;
    localparam int SP_W      = 32;
    localparam int SP_EXP_W  = 8;
    localparam int SP_MAN_W  = 23;
    localparam int DP_W      = 64;
    localparam int DP_EXP_W  = 11;
    localparam int DP_MAN_W  = 52;
    localparam int SP_BIAS   = (1 << (SP_EXP_W - 1)) - 1;
    localparam int DP_BIAS   = (1 << (DP_EXP_W - 1)) - 1;
    localparam int BIAS_GAP  = DP_BIAS - SP_BIAS;
    localparam int MAN_PAD   = DP_MAN_W - SP_MAN_W;
    localparam int LZ_W      = $clog2(SP_MAN_W + 1);

    typedef enum logic {
        OP_LOAD_HI = 1'b0,
        OP_SET_LO  = 1'b1
    } fpimm_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } fpimm_st_e;
endpackage

// File: rtl/fpimm_lzc.sv
module fpimm_lzc #(
    parameter int W  = 23,
    parameter int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  vec,
    output logic [CW-1:0] cnt
);
    // Count of zero bits above the highest set bit; W when vec is zero.
    always_comb begin
        cnt = CW'(W);
        for (int i = 0; i < W; i++) begin
            if (vec[i]) cnt = CW'(W - 1 - i);
        end
    end
endmodule

// File: rtl/fpimm_widen.sv
module fpimm_widen
    import fpimm_pkg::*;
(
    input  logic [SP_W-1:0] sp_in,
    output logic [DP_W-1:0] dp_out
);
    logic                  sgn;
    logic [SP_EXP_W-1:0]   exp_s;
    logic [SP_MAN_W-1:0]   man_s;
    logic [LZ_W-1:0]       lead_z;
    logic [DP_MAN_W-1:0]   sub_frac;

    assign sgn   = sp_in[SP_W-1];
    assign exp_s = sp_in[SP_W-2 -: SP_EXP_W];
    assign man_s = sp_in[SP_MAN_W-1:0];

    fpimm_lzc #(.W(SP_MAN_W), .CW(LZ_W)) lzc_i (
        .vec (man_s),
        .cnt (lead_z)
    );

    // Denormal: shift out the leading one so the rest is left-aligned.
    assign sub_frac = {man_s, {MAN_PAD{1'b0}}} << (32'(lead_z) + 32'd1);

    always_comb begin
        if (exp_s == {SP_EXP_W{1'b1}}) begin
            dp_out = {sgn, {DP_EXP_W{1'b1}}, man_s, {MAN_PAD{1'b0}}};
        end else if (exp_s == '0 && man_s == '0) begin
            dp_out = {sgn, {(DP_W-1){1'b0}}};
        end else if (exp_s == '0) begin
            dp_out = {sgn, DP_EXP_W'(BIAS_GAP) - DP_EXP_W'(lead_z), sub_frac};
        end else begin
            dp_out = {sgn, DP_EXP_W'(exp_s) + DP_EXP_W'(BIAS_GAP), man_s, {MAN_PAD{1'b0}}};
        end
    end
endmodule

// File: rtl/fpimm_narrow.sv
module fpimm_narrow
    import fpimm_pkg::*;
(
    input  logic [DP_W-1:0] dp_in,
    output logic [SP_W-1:0] sp_out
);
    localparam int E_MIN_SUB  = BIAS_GAP - SP_MAN_W + 1;
    localparam int E_MIN_NORM = BIAS_GAP + 1;
    localparam int E_MAX_NORM = BIAS_GAP + (1 << SP_EXP_W) - 2;

    logic                  sgn;
    logic [DP_EXP_W-1:0]   exp_d;
    logic [SP_MAN_W-1:0]   frac_top;
    logic                  low_nz;
    logic [DP_EXP_W-1:0]   sub_sh;
    logic [SP_MAN_W:0]     sub_man;
    logic [SP_MAN_W-1:0]   nan_man;

    assign sgn      = dp_in[DP_W-1];
    assign exp_d    = dp_in[DP_W-2 -: DP_EXP_W];
    assign frac_top = dp_in[DP_MAN_W-1 -: SP_MAN_W];
    assign low_nz   = |dp_in[MAN_PAD-1:0];
    assign sub_sh   = DP_EXP_W'(E_MIN_NORM) - exp_d;
    assign sub_man  = {1'b1, frac_top} >> sub_sh;
    assign nan_man  = (frac_top == '0 && low_nz) ? {1'b1, {(SP_MAN_W-1){1'b0}}} : frac_top;

    always_comb begin
        if (exp_d == {DP_EXP_W{1'b1}}) begin
            sp_out = {sgn, {SP_EXP_W{1'b1}}, nan_man};
        end else if (exp_d < DP_EXP_W'(E_MIN_SUB)) begin
            sp_out = {sgn, {(SP_W-1){1'b0}}};
        end else if (exp_d > DP_EXP_W'(E_MAX_NORM)) begin
            sp_out = {sgn, {SP_EXP_W{1'b1}}, {SP_MAN_W{1'b0}}};
        end else if (exp_d >= DP_EXP_W'(E_MIN_NORM)) begin
            sp_out = {sgn, SP_EXP_W'(exp_d - DP_EXP_W'(BIAS_GAP)), frac_top};
        end else begin
            sp_out = {sgn, {SP_EXP_W{1'b0}}, sub_man[SP_MAN_W-1:0]};
        end
    end
endmodule

// File: rtl/fpimm_build.sv
module fpimm_build
    import fpimm_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_vld,
    input  logic                 in_op,
    input  logic [IMM_W-1:0]     in_imm,
    input  logic [DP_W-1:0]      in_old,
    output logic                 out_vld,
    output logic [DP_W-1:0]      out_data
);
    localparam int HALF_W = SP_W - IMM_W;

    fpimm_op_e        op;
    fpimm_st_e        st_q, st_d;
    logic [SP_W-1:0]  old_sp;
    logic [SP_W-1:0]  new_sp;
    logic [DP_W-1:0]  new_dp;
    logic [DP_W-1:0]  data_q;

    assign op = fpimm_op_e'(in_op);

    fpimm_narrow narrow_i (
        .dp_in  (in_old),
        .sp_out (old_sp)
    );

    always_comb begin
        unique case (op)
            OP_LOAD_HI: new_sp = {in_imm, {HALF_W{1'b0}}};
            OP_SET_LO:  new_sp = {old_sp[SP_W-1 -: HALF_W], in_imm};
            default:    new_sp = '0;
        endcase
    end

    fpimm_widen widen_i (
        .sp_in  (new_sp),
        .dp_out (new_dp)
    );

    // Next-state logic.
    always_comb begin
        unique case (st_q)
            ST_IDLE: st_d = in_vld ? ST_EMIT : ST_IDLE;
            ST_EMIT: st_d = in_vld ? ST_EMIT : ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_IDLE;
        else     st_q <= st_d;
    end

    // Output register.
    always_ff @(posedge clk) begin
        if (in_vld) data_q <= new_dp;
    end

    assign out_vld  = (st_q == ST_EMIT);
    assign out_data = data_q;

    p_rst_clear_r1: assert property (@(posedge clk) rst |=> !out_vld)
        else $error("R1 violated");
    p_vld_follow_r2: assert property (@(posedge clk) disable iff (rst) in_vld |=> out_vld)
        else $error("R2 violated");
    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst) !in_vld |=> !out_vld)
        else $error("R2 violated");
    p_load_pad_r3: assert property (@(posedge clk) disable iff (rst)
        (in_vld && !in_op) |=> (out_data[MAN_PAD-1:0] == '0))
        else $error("R3 violated");
    p_load_sign_r6: assert property (@(posedge clk) disable iff (rst)
        (in_vld && !in_op) |=> (out_data[DP_W-1] == $past(in_imm[IMM_W-1])))
        else $error("R6 violated");
    p_load_inf_r6: assert property (@(posedge clk) disable iff (rst)
        (in_vld && !in_op && in_imm[IMM_W-2 -: SP_EXP_W] == '1)
        |=> (out_data[DP_W-2 -: DP_EXP_W] == '1))
        else $error("R6 violated");
    p_set_sign_r8: assert property (@(posedge clk) disable iff (rst)
        (in_vld && in_op) |=> (out_data[DP_W-1] == $past(in_old[DP_W-1])))
        else $error("R8 violated");
    p_hold_r10: assert property (@(posedge clk) disable iff (rst) !in_vld |=> $stable(out_data))
        else $error("R10 violated");
endmodule

// File: tb/fpimm_build_tb.sv
`timescale 1ns/1ps
module fpimm_build_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_vld = 1'b0;
    logic        in_op = 1'b0;
    logic [15:0] in_imm = '0;
    logic [63:0] in_old = '0;
    logic        out_vld;
    logic [63:0] out_data;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    bit          pend_vld = 0;
    logic [63:0] pend_data = '0;
    string       pend_tag = "";
    bit          have_prev = 0;
    logic [63:0] prev_data = '0;

    always #4 clk = ~clk;

    fpimm_build dut_i (
        .clk(clk), .rst(rst), .in_vld(in_vld), .in_op(in_op),
        .in_imm(in_imm), .in_old(in_old), .out_vld(out_vld), .out_data(out_data)
    );

    function automatic logic [63:0] m_widen(input logic [31:0] s);
        int p;
        logic [63:0] f;
        if (s[30:23] == 8'hFF) return {s[31], 11'h7FF, s[22:0], 29'd0};
        if (s[30:0] == 31'd0) return {s[31], 63'd0};
        if (s[30:23] != 8'd0) return {s[31], 11'(int'(s[30:23]) + 1023 - 127), s[22:0], 29'd0};
        p = 0;
        for (int i = 0; i < 23; i++) if (s[i]) p = i;
        f = 64'(s[22:0]) << (52 - p);
        f = f & ((64'd1 << 52) - 64'd1);
        return {s[31], 11'(p + 874), f[51:0]};
    endfunction

    function automatic logic [31:0] m_narrow(input logic [63:0] d);
        int ee;
        logic [22:0] m;
        logic [23:0] w;
        if (d[62:52] == 11'h7FF) begin
            m = d[51:29];
            if (d[51:0] != 52'd0 && m == 23'd0) m = 23'h400000;
            return {d[63], 8'hFF, m};
        end
        if (d[62:52] == 11'd0) return {d[63], 31'd0};
        ee = int'(d[62:52]) - 1023 + 127;
        if (ee >= 255) return {d[63], 8'hFF, 23'd0};
        if (ee >= 1) return {d[63], 8'(ee), d[51:29]};
        if (1 - ee > 23) return {d[63], 31'd0};
        w = {1'b1, d[51:29]} >> (1 - ee);
        return {d[63], 8'd0, w[22:0]};
    endfunction

    function automatic logic [63:0] m_op(input bit op, input logic [15:0] imm, input logic [63:0] old);
        logic [31:0] n;
        if (!op) return m_widen({imm, 16'd0});
        n = m_narrow(old);
        return m_widen({n[31:16], imm});
    endfunction

    task automatic check_out();
        n_cmp++;
        if (out_vld !== pend_vld) begin
            n_bad++;
            $display("FAIL R2 (%s): out_vld=%0b expected %0b", pend_tag, out_vld, pend_vld);
        end
        if (pend_vld) begin
            n_cmp++;
            if (out_data !== pend_data) begin
                n_bad++;
                $display("FAIL %s: out_data=%h expected %h", pend_tag, out_data, pend_data);
            end
        end else if (have_prev) begin
            n_cmp++;
            if (out_data !== prev_data) begin
                n_bad++;
                $display("FAIL R10: out_data=%h expected %h", out_data, prev_data);
            end
        end
        if (pend_vld) have_prev = 1;
        prev_data = out_data;
    endtask

    task automatic step(input bit vld, input bit op, input logic [15:0] imm,
                        input logic [63:0] old, input bit fb,
                        input logic [63:0] expd, input string tag);
        @(negedge clk);
        check_out();
        in_vld = vld;
        in_op  = op;
        in_imm = imm;
        in_old = fb ? out_data : old;
        pend_vld  = vld;
        pend_data = expd;
        pend_tag  = vld ? tag : "R10";
    endtask

    task automatic step_m(input bit op, input logic [15:0] imm, input logic [63:0] old, input string tag);
        step(1'b1, op, imm, old, 1'b0, m_op(op, imm, old), tag);
    endtask

    task automatic idle();
        step(1'b0, 1'b0, 16'd0, 64'd0, 1'b0, 64'd0, "R10");
    endtask

    task automatic chain(input logic [31:0] c);
        step(1'b1, 1'b0, c[31:16], 64'hDEAD_BEEF_0123_4567, 1'b0, m_widen({c[31:16], 16'd0}), "R3");
        step(1'b1, 1'b1, c[15:0], 64'd0, 1'b1, m_widen(c), "R9");
    endtask

    initial begin
        // R1: reset holds the strobe low, even with a request present
        repeat (2) begin
            @(negedge clk);
            in_vld = 1'b1;
            n_cmp++;
            if (out_vld !== 1'b0) begin
                n_bad++;
                $display("FAIL R1: out_vld=%0b expected 0", out_vld);
            end
        end
        @(negedge clk);
        n_cmp++;
        if (out_vld !== 1'b0) begin
            n_bad++;
            $display("FAIL R1: out_vld=%0b expected 0", out_vld);
        end
        rst = 1'b0;
        in_vld = 1'b0;
        pend_vld = 0;

        // R5 hand-computed normals
        step(1, 0, 16'h3F80, 64'hFFFF_FFFF_FFFF_FFFF, 0, 64'h3FF0_0000_0000_0000, "R5");
        step(1, 0, 16'hC000, 64'd0, 0, 64'hC000_0000_0000_0000, "R5");
        // R6 specials
        step(1, 0, 16'hFF80, 64'd0, 0, 64'hFFF0_0000_0000_0000, "R6");
        step(1, 0, 16'h8000, 64'd0, 0, 64'h8000_0000_0000_0000, "R6");
        step(1, 0, 16'h7FC0, 64'd0, 0, 64'h7FF8_0000_0000_0000, "R6");
        idle();
        idle();
        // R7 denormal immediate
        step(1, 0, 16'h0040, 64'd0, 0, 64'h3800_0000_0000_0000, "R7");
        step_m(0, 16'h8001, 64'd0, "R7");
        // R4 set-low
        step(1, 1, 16'h1234, 64'h3FF0_0000_0000_0000, 0, 64'h3FF0_0246_8000_0000, "R4");
        // R8: low 29 bits of the old value ignored
        step(1, 1, 16'h1234, 64'h3FF0_0000_1FFF_FFFF, 0, 64'h3FF0_0246_8000_0000, "R8");
        step(1, 1, 16'h0000, 64'h7FE0_0000_0000_0000, 0, 64'h7FF0_0000_0000_0000, "R8");
        step(1, 1, 16'h0000, 64'h7FF0_0000_0000_0001, 0, 64'h7FF8_0000_0000_0000, "R8");
        step(1, 1, 16'h0005, 64'h0010_0000_0000_0000, 0, 64'h36C4_0000_0000_0000, "R8");
        step_m(1, 16'hABCD, 64'hC7EF_FFFF_E000_0000, "R8");
        step_m(1, 16'h0F0F, 64'h3690_0000_0000_0000, "R8");
        step_m(1, 16'h5555, 64'h3800_0000_0000_0000, "R8");
        step_m(1, 16'h0001, 64'h3690_0000_0000_0000, "R8");
        idle();
        // R9 chaining through the block itself
        step(1, 0, 16'h0000, 64'd0, 0, 64'd0, "R6");
        step(1, 1, 16'h0001, 64'd0, 1, 64'h36A0_0000_0000_0000, "R9");
        chain(32'h4049_0FDB);
        chain(32'hC2F6_E979);
        chain(32'h0001_2345);
        chain(32'h807F_FFFF);
        chain(32'h7F7F_FFFF);
        chain(32'h3DCC_CCCD);
        chain(32'h7F80_0005);
        chain(32'hFFC0_0001);
        for (int k = 0; k < 24; k++) begin
            chain($urandom);
            if (k % 5 == 0) idle();
        end
        for (int k = 0; k < 16; k++) begin
            step_m(1'b1, 16'($urandom), {$urandom, $urandom}, "R8");
        end
        idle();
        @(negedge clk);
        check_out();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule